// File: doc/BRIEF.md
# Fixed-Head Disk Controller Programmed-I/O Front End

This block is the register and decode stage of a fixed-head disk controller that sits on a 12-bit minicomputer's programmed-I/O bus. The processor issues a one-cycle strobe with a 2-bit group code, a 3-bit pulse field and its 12-bit accumulator. During that strobe the block returns a new accumulator value and a skip flag. Any register change lands on the clock edge that ends the strobe.

The block holds three pieces of state. The first is an 11-bit stored status word: the disk-address extension, the memory-field extension and three sticky error bits. The top status bit is not stored; it is the live photocell input. The second is a 12-bit disk address. The third is a done flag. Starting a transfer raises a registered one-cycle start command with a read/write indication. The transfer engine, which is a separate block, reports back through a done pulse, error-set lines and a rotational address-match bit. Done completions raise an interrupt request that stays up until software clears it.

Top module: `dskio_ctl`

## Requirements
- R1: After reset, the stored status bits are 0, the disk address is 0, done is 1 and irq is 0.
- R2: Group 0 with pulse bit 0 clears the disk address, done, status bits 2..0 (the errors) and irq on the next edge.
- R3: Group 0 with pulse bit 1 or bit 2 ORs the accumulator into the disk address (after any pulse-bit-0 clear in the same strobe) and returns 0. In the cycle after the strobe it raises xfer_start for one cycle, with xfer_wr = 1 when pulse bit 2 is set and 0 otherwise.
- R4: Group 1 with pulse bit 0 clears status bits 10..3. With pulse bit 2, the strobe ORs (accumulator AND 12'o3770) into the status, applied after any such clear. It returns the accumulator ORed with the full status read value from before the strobe.
- R5: Group 1 with pulse bit 1 zeroes the accumulator before any pulse-bit-2 action and raises skip exactly when pos_match is 1.
- R6: Group 2 with pulse bit 0 raises skip when status bits 2..0 are all 0.
- R7: Group 2 with pulse bit 1 and without pulse bit 2 raises skip when done is 1. With both bits set, the accumulator is zeroed and done does not cause a skip.
- R8: Group 2 with pulse bit 2 returns the accumulator (after any R7 zeroing) ORed with the disk address.
- R9: A xfer_done pulse sets done and irq on the next edge. irq then stays 1 until a group-0 pulse-bit-0 strobe or reset. If xfer_done and such a clear arrive together, the set wins.
- R10: Each err_set bit sets the matching status bit 0..2 (bit 2 data late, bit 1 write lock, bit 0 parity). The bit stays set until cleared. A set arriving together with a clear wins.
- R11: With no strobe, or with group code 3, ac_out equals ac_in, skip is 0 and no register changes.
- R12: Status bit 11, as seen on status and in group-1 reads, is the live pcell input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iot_stb | input | 1 | One-cycle I/O instruction strobe |
| iot_grp | input | 2 | Instruction group code (0..2 used) |
| iot_pulse | input | 3 | Pulse bits of the instruction |
| ac_in | input | 12 | Accumulator from the processor |
| pcell | input | 1 | Photocell indicator |
| pos_match | input | 1 | Disk address matches rotational position |
| xfer_done | input | 1 | Transfer engine completion pulse |
| err_set | input | 3 | Error set lines {late, lock, parity} |
| ac_out | output | 12 | Returned accumulator (combinational) |
| skip | output | 1 | Skip request (combinational) |
| irq | output | 1 | Interrupt request |
| xfer_start | output | 1 | One-cycle transfer start command |
| xfer_wr | output | 1 | Direction of the started transfer, 1 = write |
| disk_addr | output | 12 | Disk address register |
| status | output | 12 | Status read value |

## Verification
The returned accumulator and skip belong to the strobe cycle itself, so the monitor compares them at the falling edge inside that cycle. It pops the expectation the driver queued when it raised the strobe. Register effects, irq and xfer_start/xfer_wr appear one edge later. The driver therefore checks them at the falling edge after it drops the strobe. Later read-back strobes through groups 1 and 2 confirm the same state a second time.

// File: rtl/dskio_pkg.sv
package dskio_pkg;
  parameter int unsigned DW      = 12;
  parameter int unsigned GRP_W   = 2;
  parameter int unsigned PULSE_W = 3;
  parameter int unsigned ERR_W   = 3;
  localparam int unsigned STA_W   = DW - 1;
  localparam int unsigned MEX_LSB = ERR_W;
  localparam int unsigned MEX_W   = 3;
  localparam int unsigned DEX_LSB = MEX_LSB + MEX_W;
  localparam int unsigned DEX_W   = STA_W - DEX_LSB;
  localparam logic [STA_W-1:0] EXT_MASK = {{(DEX_W + MEX_W){1'b1}}, {ERR_W{1'b0}}};

  typedef enum logic [GRP_W-1:0] {
    GRP_CTL = 2'd0,
    GRP_EXT = 2'd1,
    GRP_TST = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;

  typedef struct packed {
    logic clr_all;
    logic load_da;
    logic fn_wr;
    logic clr_ext;
    logic chk_pos;
    logic ext_xfer;
    logic sk_err;
    logic sk_done;
    logic clr_ac;
    logic rd_da;
  } op_t;
endpackage

// File: rtl/dskio_decode.sv
module dskio_decode
  import dskio_pkg::*;
(
  input  logic               stb,
  input  logic [GRP_W-1:0]   grp,
  input  logic [PULSE_W-1:0] pulse,
  output op_t                op
);
  logic g_ctl, g_ext, g_tst;

  always_comb begin
    g_ctl = stb && (grp_e'(grp) == GRP_CTL);
    g_ext = stb && (grp_e'(grp) == GRP_EXT);
    g_tst = stb && (grp_e'(grp) == GRP_TST);
    op = '0;
    op.clr_all  = g_ctl && pulse[0];
    op.load_da  = g_ctl && (pulse[1] || pulse[2]);
    op.fn_wr    = pulse[2];
    op.clr_ext  = g_ext && pulse[0];
    op.chk_pos  = g_ext && pulse[1];
    op.ext_xfer = g_ext && pulse[2];
    op.sk_err   = g_tst && pulse[0];
    op.sk_done  = g_tst && pulse[1] && !pulse[2];
    op.clr_ac   = g_tst && pulse[1] && pulse[2];
    op.rd_da    = g_tst && pulse[2];
  end
endmodule

// File: rtl/dskio_regs.sv
module dskio_regs
  import dskio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  op_t              op,
  input  logic [DW-1:0]    ac_in,
  input  logic             xfer_done,
  input  logic [ERR_W-1:0] err_set,
  output logic [STA_W-1:0] sta_q,
  output logic [DW-1:0]    da_q,
  output logic             done_q,
  output logic             irq_q,
  output logic             start_q,
  output logic             wr_q
);
  logic [STA_W-1:0] sta_n;
  logic [DW-1:0]    da_n;
  logic [STA_W-1:0] ext_src;

  always_comb begin
    da_n = da_q;
    if (op.clr_all) da_n = '0;
    if (op.load_da) da_n = da_n | ac_in;

    ext_src = op.chk_pos ? '0 : ac_in[STA_W-1:0];
    sta_n = sta_q;
    if (op.clr_all)  sta_n[ERR_W-1:0] = '0;
    if (op.clr_ext)  sta_n = sta_n & ~EXT_MASK;
    if (op.ext_xfer) sta_n = sta_n | (ext_src & EXT_MASK);
    sta_n[ERR_W-1:0] = sta_n[ERR_W-1:0] | err_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sta_q   <= '0;
      da_q    <= '0;
      done_q  <= 1'b1;
      irq_q   <= 1'b0;
      start_q <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      sta_q   <= sta_n;
      da_q    <= da_n;
      start_q <= op.load_da;
      if (op.load_da) wr_q <= op.fn_wr;
      if (xfer_done) begin
        done_q <= 1'b1;
        irq_q  <= 1'b1;
      end else if (op.clr_all) begin
        done_q <= 1'b0;
        irq_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dskio_acpath.sv
module dskio_acpath
  import dskio_pkg::*;
(
  input  op_t              op,
  input  logic [DW-1:0]    ac_in,
  input  logic [STA_W-1:0] sta_q,
  input  logic             pcell,
  input  logic [DW-1:0]    da_q,
  input  logic             done_q,
  input  logic             pos_match,
  output logic [DW-1:0]    ac_out,
  output logic             skip
);
  logic [DW-1:0] acw;

  always_comb begin
    acw  = ac_in;
    skip = 1'b0;
    if (op.load_da) acw = '0;
    if (op.chk_pos) begin
      acw  = '0;
      skip = pos_match;
    end
    if (op.ext_xfer) acw = acw | {pcell, sta_q};
    if (op.sk_err && (sta_q[ERR_W-1:0] == '0)) skip = 1'b1;
    if (op.sk_done && done_q) skip = 1'b1;
    if (op.clr_ac) acw = '0;
    if (op.rd_da) acw = acw | da_q;
    ac_out = acw;
  end
endmodule

// File: rtl/dskio_ctl.sv
module dskio_ctl
  import dskio_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               iot_stb,
  input  logic [GRP_W-1:0]   iot_grp,
  input  logic [PULSE_W-1:0] iot_pulse,
  input  logic [DW-1:0]      ac_in,
  input  logic               pcell,
  input  logic               pos_match,
  input  logic               xfer_done,
  input  logic [ERR_W-1:0]   err_set,
  output logic [DW-1:0]      ac_out,
  output logic               skip,
  output logic               irq,
  output logic               xfer_start,
  output logic               xfer_wr,
  output logic [DW-1:0]      disk_addr,
  output logic [DW-1:0]      status
);
  op_t              op;
  logic [STA_W-1:0] sta_q;
  logic [DW-1:0]    da_q;
  logic             done_q;

  dskio_decode u_dec (
    .stb   (iot_stb),
    .grp   (iot_grp),
    .pulse (iot_pulse),
    .op    (op)
  );

  dskio_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .ac_in     (ac_in),
    .xfer_done (xfer_done),
    .err_set   (err_set),
    .sta_q     (sta_q),
    .da_q      (da_q),
    .done_q    (done_q),
    .irq_q     (irq),
    .start_q   (xfer_start),
    .wr_q      (xfer_wr)
  );

  dskio_acpath u_ac (
    .op        (op),
    .ac_in     (ac_in),
    .sta_q     (sta_q),
    .pcell     (pcell),
    .da_q      (da_q),
    .done_q    (done_q),
    .pos_match (pos_match),
    .ac_out    (ac_out),
    .skip      (skip)
  );

  assign disk_addr = da_q;
  assign status    = {pcell, sta_q};
endmodule

// File: rtl/dskio_ctl_chk.sv
module dskio_ctl_chk
  import dskio_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               iot_stb,
  input logic [GRP_W-1:0]   iot_grp,
  input logic [PULSE_W-1:0] iot_pulse,
  input logic [DW-1:0]      ac_in,
  input logic               pos_match,
  input logic               xfer_done,
  input logic [ERR_W-1:0]   err_set,
  input logic [DW-1:0]      ac_out,
  input logic               skip,
  input logic               irq,
  input logic               xfer_start,
  input logic [DW-1:0]      disk_addr,
  input logic [DW-1:0]      status
);
  logic ld, clr;
  assign ld  = iot_stb && (iot_grp == 2'd0) && (iot_pulse[1] || iot_pulse[2]);
  assign clr = iot_stb && (iot_grp == 2'd0) && iot_pulse[0];

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (rst)
    ld |=> xfer_start); // R3
  AST_START_CAUSE: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> $past(ld)); // R3
  AST_LOAD_ZERO_AC: assert property (@(posedge clk) disable iff (rst)
    ld |-> (ac_out == '0)); // R3
  AST_DA_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr && !ld) |=> (disk_addr == '0)); // R2
  AST_POS_SKIP: assert property (@(posedge clk) disable iff (rst)
    (iot_stb && iot_grp == 2'd1 && iot_pulse[1]) |-> (skip == pos_match)); // R5
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (!iot_stb || iot_grp == 2'd3) |-> (!skip && ac_out == ac_in)); // R11
  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> irq); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr) |=> irq); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_set != '0) |=> ((status[ERR_W-1:0] & $past(err_set)) == $past(err_set))); // R10
endmodule

bind dskio_ctl dskio_ctl_chk u_chk (.*);

// File: tb/dskio_ctl_bench.sv
module dskio_ctl_bench;
  logic        clk = 0, rst = 1;
  logic        iot_stb = 0, pcell = 0, pos_match = 0, xfer_done = 0;
  logic [1:0]  iot_grp = 0;
  logic [2:0]  iot_pulse = 0, err_set = 0;
  logic [11:0] ac_in = 0;
  logic [11:0] ac_out, disk_addr, status;
  logic        skip, irq, xfer_start, xfer_wr;

  always #5 clk = ~clk;

  dskio_ctl u_dskio_ctl (.*);

  typedef struct { logic [11:0] ac; logic sk; string req; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [10:0] m_sta;
  logic [11:0] m_da;
  logic        m_done, m_irq;

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%o expected=%o", req, act, exp);
    end
  endtask

  // monitor: pops one expectation per strobe cycle
  always @(negedge clk) begin
    if (!rst && iot_stb) begin
      if (q.size() == 0) chk("queue", 12'd1, 12'd0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk({e.req, " ac"}, ac_out, e.ac);
        chk({e.req, " skip"}, {11'd0, skip}, {11'd0, e.sk});
      end
    end
  end

  task automatic iot(input logic stb, input logic [1:0] g, input logic [2:0] p,
                     input logic [11:0] ac, input logic dn, input logic [2:0] er,
                     input string req);
    exp_t e;
    logic [11:0] acw, old_rd;
    logic sk, st, wr;
    old_rd = {pcell, m_sta};
    acw = ac; sk = 0; st = 0; wr = 0;
    if (stb && g == 0) begin
      if (p[0]) begin m_da = 0; m_sta[2:0] = 0; m_done = 0; m_irq = 0; end
      if (p[1] | p[2]) begin m_da = m_da | ac; acw = 0; st = 1; wr = p[2]; end
    end else if (stb && g == 1) begin
      if (p[1]) begin acw = 0; sk = pos_match; end
      if (p[0]) m_sta = m_sta & ~11'o3770;
      if (p[2]) begin m_sta = m_sta | (acw[10:0] & 11'o3770); acw = acw | old_rd; end
    end else if (stb && g == 2) begin
      if (p[0] && old_rd[2:0] == 0) sk = 1;
      if (p[1]) begin if (p[2]) acw = 0; else if (m_done) sk = 1; end
      if (p[2]) acw = acw | m_da;
    end
    if (dn) begin m_done = 1; m_irq = 1; end
    m_sta[2:0] = m_sta[2:0] | er;
    e.ac = acw; e.sk = sk; e.req = req;
    @(posedge clk); #1;
    if (stb) q.push_back(e);
    iot_stb = stb; iot_grp = g; iot_pulse = p; ac_in = ac; xfer_done = dn; err_set = er;
    @(posedge clk); #1;
    iot_stb = 0; xfer_done = 0; err_set = 0;
    @(negedge clk);
    chk({req, " start"}, {11'd0, xfer_start}, {11'd0, st});
    if (st) chk({req, " wr"}, {11'd0, xfer_wr}, {11'd0, wr});
    chk({req, " irq"}, {11'd0, irq}, {11'd0, m_irq});
    chk({req, " da"}, disk_addr, m_da);
    chk({req, " status"}, status, {pcell, m_sta});
  endtask

  initial begin
    m_sta = 0; m_da = 0; m_done = 1; m_irq = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status, 12'o0000);
    chk("R1 da", disk_addr, 12'o0000);
    chk("R1 irq", {11'd0, irq}, 12'd0);
    iot(1, 2, 3'b010, 12'o0000, 0, 0, "R1 done-skip");
    // R2 clear
    iot(1, 0, 3'b001, 12'o0000, 0, 0, "R2");
    iot(1, 2, 3'b010, 12'o0000, 0, 0, "R2 done cleared");
    // R3 load/start
    iot(1, 0, 3'b010, 12'o1234, 0, 0, "R3 read");
    iot(1, 0, 3'b100, 12'o0041, 0, 0, "R3 write");
    iot(1, 0, 3'b011, 12'o0007, 0, 0, "R3 clear-then-load");
    // R8 read disk address
    iot(1, 2, 3'b100, 12'o7000, 0, 0, "R8");
    // R4 extension load and readback
    iot(1, 1, 3'b100, 12'o3777, 0, 0, "R4 or-in");
    pcell = 1;
    iot(1, 1, 3'b100, 12'o0000, 0, 0, "R12 pcell read");
    iot(1, 1, 3'b101, 12'o0150, 0, 0, "R4 clear+or");
    iot(1, 1, 3'b001, 12'o0000, 0, 0, "R4 clear");
    pcell = 0;
    // R5 position compare
    pos_match = 1;
    iot(1, 1, 3'b010, 12'o5555, 0, 0, "R5 match");
    pos_match = 0;
    iot(1, 1, 3'b010, 12'o5555, 0, 0, "R5 nomatch");
    iot(1, 1, 3'b110, 12'o3770, 0, 0, "R5 zero before or");
    // R6 / R10 errors
    iot(1, 2, 3'b001, 12'o0000, 0, 0, "R6 no error");
    iot(0, 0, 3'b000, 12'o0000, 0, 3'b100, "R10 set late");
    iot(1, 2, 3'b001, 12'o0000, 0, 0, "R6 error present");
    iot(1, 0, 3'b001, 12'o0000, 0, 3'b001, "R10 set beats clear");
    iot(1, 0, 3'b001, 12'o0000, 0, 0, "R10 clear");
    iot(1, 2, 3'b001, 12'o0000, 0, 0, "R6 after clear");
    // R9 / R7 done and irq
    iot(0, 0, 3'b000, 12'o0000, 1, 0, "R9 done pulse");
    iot(0, 0, 3'b000, 12'o0000, 0, 0, "R9 irq held");
    iot(1, 2, 3'b010, 12'o0000, 0, 0, "R7 done skip");
    iot(1, 2, 3'b110, 12'o1111, 0, 0, "R7 suppressed");
    iot(1, 0, 3'b001, 12'o0000, 1, 0, "R9 set beats clear");
    iot(1, 0, 3'b001, 12'o0000, 0, 0, "R9 clear");
    // R11 group 3 and idle
    iot(1, 0, 3'b010, 12'o0321, 0, 0, "R3 reload");
    iot(1, 3, 3'b111, 12'o4321, 0, 0, "R11 group3");
    iot(0, 1, 3'b111, 12'o7777, 0, 0, "R11 idle");
    @(negedge clk);
    chk("R11 idle ac", ac_out, ac_in);
    chk("queue drained", 12'(q.size()), 12'd0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule